// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block turns a single serial input line back into data words. The frame shape is selected at run time: the word length is 5 to 9 bits, parity is none, even or odd, and the stop field is one or two bits long. These are the same format settings the companion transmitter uses. A frame is one low start bit, the data bits least significant first, an optional parity bit, and then the stop bits, which are high. The line rests high between frames.

In asynchronous mode, an oversampling tick runs at 16 times the bit rate. A falling edge on the idle line starts a bit timer. Each bit is decided at its centre by a majority vote of three consecutive samples. In synchronous mode, an incoming serial clock supplies the timing instead. A polarity input selects which edge of that clock samples the line. Both the line and the serial clock pass through a two-stage synchronizer before any edge is detected.

Each completed frame produces a one-cycle valid pulse, together with the zero-extended word, a parity-error flag and a framing-error flag. These outputs hold their values until the next frame completes.

Top module: `frame_rx`

## Requirements
- R1: While reset is high, and after it is released, rx_valid, rx_word, par_err and frm_err are all zero.
- R2: In asynchronous mode with os_tick asserted 16 times per bit, a frame is assembled least significant bit first, and rx_word shows the data bits in its low positions.
- R3: data_len selects the word length: code 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8, and any code of 4 or above gives 9. Unused upper bits of rx_word read as zero.
- R4: par_mode selects parity: 1 is even, 2 is odd, and 0 or 3 means no parity bit. par_err is 1 exactly when the bit after the data does not give the selected total parity.
- R5: frm_err is 1 when the first stop bit is sampled low. The word is still delivered in that case.
- R6: With two_stop = 1, rx_valid occurs during the second stop bit rather than the first. The level of the second stop bit is never flagged.
- R7: In asynchronous mode, a start bit that reads high at its centre is dropped. No word is produced, and the next proper frame is received normally.
- R8: Each asynchronous bit is the majority of three consecutive samples at its centre, so a single-sample disturbance there does not change it.
- R9: With sync_mode = 1, the line is sampled on the falling edge of sclk_in when clk_pol = 0, and on the rising edge when clk_pol = 1. A sampled low while idle is taken as the start bit.
- R10: rx_valid is high for exactly one cycle per frame. rx_word and both flags keep their values until the next valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Serial data line, high when idle |
| sclk_in | input | 1 | Serial clock used in synchronous mode |
| sync_mode | input | 1 | 1 selects synchronous sampling, 0 selects oversampled asynchronous |
| clk_pol | input | 1 | Sampling edge select: 0 is falling, 1 is rising |
| os_tick | input | 1 | Oversampling strobe, 16 per bit time |
| data_len | input | 3 | Word length code (0..3 give 5..8 bits, 4 and above give 9) |
| par_mode | input | 2 | Parity: 0 or 3 none, 1 even, 2 odd |
| two_stop | input | 1 | 1 waits for a second stop bit |
| rx_word | output | 9 | Received word, zero-extended |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |
| par_err | output | 1 | Parity mismatch in the last frame |
| frm_err | output | 1 | First stop bit sampled low in the last frame |

## Verification
A wrong bit counter or a missed length decode shows up at the ports as a word shifted or truncated by one or more bits. It also moves the valid pulse into a different bit slot, which is visible within one frame. A sampler that picks the wrong serial-clock edge reads the previous bit, so the whole word appears shifted at the next valid pulse. If the start check or the majority vote is broken, a short low pulse produces a spurious word, or a mid-bit disturbance flips a data bit. Either is visible at the end of the affected frame.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

    localparam int FRX_MAX_BITS = 9;
    localparam int FRX_CNT_W    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } frx_state_t;

    typedef struct packed {
        logic stb;
        logic val;
    } bit_evt_t;

    function automatic logic [FRX_CNT_W-1:0] data_bits(input logic [2:0] code);
        case (code)
            3'd0:    data_bits = FRX_CNT_W'(5);
            3'd1:    data_bits = FRX_CNT_W'(6);
            3'd2:    data_bits = FRX_CNT_W'(7);
            3'd3:    data_bits = FRX_CNT_W'(8);
            default: data_bits = FRX_CNT_W'(FRX_MAX_BITS);
        endcase
    endfunction

    function automatic logic par_on(input logic [1:0] pm);
        par_on = (pm == 2'd1) || (pm == 2'd2);
    endfunction

    function automatic logic par_odd(input logic [1:0] pm);
        par_odd = (pm == 2'd2);
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        maj3 = (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/frx_sync.sv
module frx_sync #(
    parameter int             W      = 2,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= INIT;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= INIT;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/frx_sampler.sv
module frx_sampler
    import frame_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_s,
    input  logic     sclk_s,
    input  logic     sync_mode,
    input  logic     clk_pol,
    input  logic     os_tick,
    input  logic     hunt,
    output logic     start_det,
    output bit_evt_t evt
);
    localparam int CW = $clog2(OS_RATE);
    localparam logic [CW-1:0] MID_C  = CW'(OS_RATE / 2);
    localparam logic [CW-1:0] EARLY  = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] LATE   = CW'(OS_RATE / 2 + 1);
    localparam logic [CW-1:0] LAST   = CW'(OS_RATE - 1);

    logic          line_d, sclk_d, active;
    logic [CW-1:0] cnt;
    logic [1:0]    smp;
    logic          fall, sclk_edge, async_stb;

    assign fall      = line_d & ~line_s;
    assign sclk_edge = clk_pol ? (sclk_s & ~sclk_d) : (~sclk_s & sclk_d);
    assign start_det = hunt & ~sync_mode & fall;
    assign async_stb = active & os_tick & (cnt == LATE) & ~sync_mode;

    always_comb begin
        if (sync_mode) begin
            evt.stb = sclk_edge;
            evt.val = line_s;
        end else begin
            evt.stb = async_stb;
            evt.val = maj3(smp[0], smp[1], line_s);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_d <= 1'b1;
            sclk_d <= 1'b0;
            active <= 1'b0;
            cnt    <= '0;
            smp    <= '0;
        end else begin
            line_d <= line_s;
            sclk_d <= sclk_s;
            if (start_det) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (hunt) begin
                active <= 1'b0;
            end else if (active && os_tick) begin
                cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                if (cnt == EARLY) smp[0] <= line_s;
                if (cnt == MID_C) smp[1] <= line_s;
            end
        end
    end

    // R9: a synchronous strobe only comes with a change of the synchronized clock
    p_sync_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && evt.stb) |-> (sclk_s != sclk_d));

    // R8: an asynchronous decision is only made inside an armed bit timer
    p_vote_armed_r8: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && evt.stb) |-> (active && !hunt));
endmodule

// File: rtl/frx_deframe.sv
module frx_deframe
    import frame_rx_pkg::*;
#(
    parameter int WORD_W = FRX_MAX_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_mode,
    input  logic [2:0]        data_len,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    input  logic              start_det,
    input  bit_evt_t          evt,
    output logic              hunt,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              par_err,
    output logic              frm_err
);
    localparam int IW = FRX_CNT_W;

    frx_state_t        st;
    logic [IW-1:0]     idx;
    logic [IW-1:0]     nbits;
    logic [WORD_W-1:0] sh;
    logic              acc, perr_q, ferr_q;

    assign nbits = data_bits(data_len);
    assign hunt  = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            idx      <= '0;
            sh       <= '0;
            acc      <= 1'b0;
            perr_q   <= 1'b0;
            ferr_q   <= 1'b0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_det) begin
                        st <= ST_START;
                    end else if (sync_mode && evt.stb && !evt.val) begin
                        st     <= ST_DATA;
                        idx    <= '0;
                        sh     <= '0;
                        acc    <= 1'b0;
                        perr_q <= 1'b0;
                    end
                end
                ST_START: begin
                    if (evt.stb) begin
                        if (evt.val) begin
                            st <= ST_IDLE;
                        end else begin
                            st     <= ST_DATA;
                            idx    <= '0;
                            sh     <= '0;
                            acc    <= 1'b0;
                            perr_q <= 1'b0;
                        end
                    end
                end
                ST_DATA: begin
                    if (evt.stb) begin
                        sh[idx] <= evt.val;
                        acc     <= acc ^ evt.val;
                        if (idx == nbits - 1'b1)
                            st <= par_on(par_mode) ? ST_PAR : ST_STOP1;
                        else
                            idx <= idx + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (evt.stb) begin
                        perr_q <= acc ^ evt.val ^ par_odd(par_mode);
                        st     <= ST_STOP1;
                    end
                end
                ST_STOP1: begin
                    if (evt.stb) begin
                        ferr_q <= ~evt.val;
                        if (two_stop) begin
                            st <= ST_STOP2;
                        end else begin
                            rx_valid <= 1'b1;
                            rx_word  <= sh;
                            par_err  <= perr_q;
                            frm_err  <= ~evt.val;
                            st       <= ST_IDLE;
                        end
                    end
                end
                ST_STOP2: begin
                    if (evt.stb) begin
                        rx_valid <= 1'b1;
                        rx_word  <= sh;
                        par_err  <= perr_q;
                        frm_err  <= ferr_q;
                        st       <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R10: the completion pulse lasts one cycle
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R10: the word only moves together with a valid pulse
    p_word_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |-> $stable(rx_word));

    // R7: a high start-bit centre sends the machine back to hunting
    p_glitch_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_START && evt.stb && evt.val) |=> (st == ST_IDLE));

    // R6: the second stop decision completes the frame
    p_stop2_done_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STOP2 && evt.stb) |=> rx_valid);

    // R3: the bit index stays inside the selected word length
    p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> (idx < nbits));

    // R4: a parity decision is followed by the stop field
    p_par_next_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PAR && evt.stb) |=> (st == ST_STOP1));
endmodule

// File: rtl/frame_rx.sv
module frame_rx
    import frame_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W      = FRX_MAX_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_line,
    input  logic              sclk_in,
    input  logic              sync_mode,
    input  logic              clk_pol,
    input  logic              os_tick,
    input  logic [2:0]        data_len,
    input  logic [1:0]        par_mode,
    input  logic              two_stop,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              par_err,
    output logic              frm_err
);
    logic [1:0] raw_in, synced;
    logic       start_det, hunt;
    bit_evt_t   evt;

    assign raw_in = {sclk_in, rx_line};

    frx_sync #(
        .W      (2),
        .STAGES (SYNC_STAGES),
        .INIT   (2'b01)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (synced)
    );

    frx_sampler #(
        .OS_RATE (OS_RATE)
    ) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .line_s    (synced[0]),
        .sclk_s    (synced[1]),
        .sync_mode (sync_mode),
        .clk_pol   (clk_pol),
        .os_tick   (os_tick),
        .hunt      (hunt),
        .start_det (start_det),
        .evt       (evt)
    );

    frx_deframe #(
        .WORD_W (WORD_W)
    ) u_deframe (
        .clk       (clk),
        .rst       (rst),
        .sync_mode (sync_mode),
        .data_len  (data_len),
        .par_mode  (par_mode),
        .two_stop  (two_stop),
        .start_det (start_det),
        .evt       (evt),
        .hunt      (hunt),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid),
        .par_err   (par_err),
        .frm_err   (frm_err)
    );
endmodule

// File: tb/frame_rx_tb_top.sv
`timescale 1ns/1ps
module frame_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic       sclk_in = 1'b0;
    logic       sync_mode = 1'b0;
    logic       clk_pol = 1'b0;
    logic       os_tick = 1'b1;
    logic [2:0] data_len = 3'd3;
    logic [1:0] par_mode = 2'd0;
    logic       two_stop = 1'b0;
    logic [8:0] rx_word;
    logic       rx_valid, par_err, frm_err;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int nvalid = 0;
    int vcyc = 0;
    logic [8:0] cap_word = '0;
    logic cap_pe = 1'b0, cap_fe = 1'b0;
    logic prev_v = 1'b0, dbl = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    frame_rx dut_i (
        .clk (clk), .rst (rst), .rx_line (rx_line), .sclk_in (sclk_in),
        .sync_mode (sync_mode), .clk_pol (clk_pol), .os_tick (os_tick),
        .data_len (data_len), .par_mode (par_mode), .two_stop (two_stop),
        .rx_word (rx_word), .rx_valid (rx_valid), .par_err (par_err),
        .frm_err (frm_err)
    );

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                nvalid++;
                cap_word = rx_word;
                cap_pe   = par_err;
                cap_fe   = frm_err;
                vcyc     = cyc;
                if (prev_v) dbl = 1'b1;
            end
            prev_v = rx_valid;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic logic [8:0] mask_of(input int nb);
        return 9'((1 << nb) - 1);
    endfunction

    // Builds the bit list of one frame; index 0 is the start bit.
    task automatic build(input logic [8:0] d, input int nb, input int pm,
                         input logic bad_par, input logic s1, input logic s2,
                         input logic ts, output logic [15:0] bits, output int n);
        logic p;
        bits = '0;
        n = 0;
        bits[n] = 1'b0; n++;
        for (int i = 0; i < nb; i++) begin bits[n] = d[i]; n++; end
        if (pm == 1 || pm == 2) begin
            p = (^(d & mask_of(nb))) ^ (pm == 2) ^ bad_par;
            bits[n] = p; n++;
        end
        bits[n] = s1; n++;
        if (ts) begin bits[n] = s2; n++; end
    endtask

    task automatic send_async(input logic [8:0] d, input int nb, input int pm,
                              input logic bad_par, input logic s1, input logic s2,
                              input logic ts, input int gl_pos,
                              output int n, output int st_cyc);
        logic [15:0] bits;
        build(d, nb, pm, bad_par, s1, s2, ts, bits, n);
        @(negedge clk);
        st_cyc = cyc;
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < 16; c++) begin
                rx_line = bits[k] ^ ((k == gl_pos) && (c == 9));
                @(negedge clk);
            end
        end
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic expect_frame(input string req, input int nv0, input logic [8:0] w,
                                input logic pe, input logic fe, input int last, input int st_cyc);
        chk({req, " valid count"}, nvalid - nv0, 1);
        chk({req, " word"}, cap_word, w);
        chk({req, " par_err"}, cap_pe, pe);
        chk({req, " frm_err"}, cap_fe, fe);
        chk({req, " valid bit slot"}, (vcyc - st_cyc) / 16, last);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 valid in reset", rx_valid, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 word", rx_word, 0);
        chk("R1 flags", {par_err, frm_err, rx_valid}, 0);
    endtask

    task automatic t_basic();
        logic [8:0] pats [4] = '{9'h055, 9'h0A3, 9'h000, 9'h0FF};
        int n, s, nv0;
        data_len = 3'd3; par_mode = 2'd0; two_stop = 1'b0;
        foreach (pats[i]) begin
            nv0 = nvalid;
            send_async(pats[i], 8, 0, 0, 1, 1, 0, -1, n, s);
            expect_frame("R2 8-bit", nv0, pats[i], 0, 0, n - 1, s);
        end
    endtask

    task automatic t_lengths();
        int n, s, nv0;
        for (int code = 0; code < 6; code++) begin
            int nb;
            nb = (code >= 4) ? 9 : code + 5;
            data_len = 3'(code);
            nv0 = nvalid;
            send_async(9'h1FF ^ 9'(code), nb, 0, 0, 1, 1, 0, -1, n, s);
            expect_frame("R3 length", nv0, (9'h1FF ^ 9'(code)) & mask_of(nb), 0, 0, n - 1, s);
        end
        data_len = 3'd3;
    endtask

    task automatic t_parity();
        int n, s, nv0;
        for (int pm = 0; pm < 4; pm++) begin
            for (int bad = 0; bad < 2; bad++) begin
                par_mode = 2'(pm);
                nv0 = nvalid;
                send_async(9'h0B6 + 9'(pm), 8, pm, 1'(bad), 1, 1, 0, -1, n, s);
                expect_frame("R4 parity", nv0, 9'h0B6 + 9'(pm),
                             (pm == 1 || pm == 2) && bad, 0, n - 1, s);
            end
        end
        par_mode = 2'd0;
    endtask

    task automatic t_framing();
        int n, s, nv0;
        nv0 = nvalid;
        send_async(9'h03C, 8, 0, 0, 0, 1, 0, -1, n, s);
        expect_frame("R5 low stop", nv0, 9'h03C, 0, 1, n - 1, s);
    endtask

    task automatic t_two_stop();
        int n, s, nv0;
        two_stop = 1'b1;
        nv0 = nvalid;
        send_async(9'h05A, 8, 0, 0, 1, 1, 1, -1, n, s);
        expect_frame("R6 two stop", nv0, 9'h05A, 0, 0, n - 1, s);
        nv0 = nvalid;
        send_async(9'h0C3, 8, 0, 0, 1, 0, 1, -1, n, s);
        expect_frame("R6 low second stop", nv0, 9'h0C3, 0, 0, n - 1, s);
        two_stop = 1'b0;
    endtask

    task automatic t_glitch();
        int n, s, nv0;
        nv0 = nvalid;
        @(negedge clk);
        rx_line = 1'b0;
        repeat (4) @(negedge clk);
        rx_line = 1'b1;
        repeat (300) @(negedge clk);
        chk("R7 no word from short low", nvalid - nv0, 0);
        nv0 = nvalid;
        send_async(9'h091, 8, 0, 0, 1, 1, 0, -1, n, s);
        expect_frame("R7 frame after glitch", nv0, 9'h091, 0, 0, n - 1, s);
    endtask

    task automatic t_majority();
        int n, s, nv0;
        nv0 = nvalid;
        // one-sample disturbances in the start bit and in data bits 0 and 5
        send_async(9'h0E4, 8, 0, 0, 1, 1, 0, 1, n, s);
        expect_frame("R8 vote data bit0", nv0, 9'h0E4, 0, 0, n - 1, s);
        nv0 = nvalid;
        send_async(9'h017, 8, 0, 0, 1, 1, 0, 6, n, s);
        expect_frame("R8 vote data bit5", nv0, 9'h017, 0, 0, n - 1, s);
        nv0 = nvalid;
        send_async(9'h06D, 8, 0, 0, 1, 1, 0, 0, n, s);
        expect_frame("R8 vote start bit", nv0, 9'h06D, 0, 0, n - 1, s);
    endtask

    task automatic sync_bit(input logic v, input logic pol);
        @(negedge clk);
        sclk_in = ~pol;
        repeat (2) @(negedge clk);
        rx_line = v;
        repeat (2) @(negedge clk);
        sclk_in = pol;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_sync(input logic pol);
        logic [15:0] bits;
        int n, nv0;
        clk_pol = pol;
        sclk_in = pol;
        rx_line = 1'b1;
        sync_mode = 1'b1;
        par_mode = 2'd1;
        data_len = 3'd4;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 3; i++) sync_bit(1'b1, pol);
        build(pol ? 9'h1A5 : 9'h0CE, 9, 1, 0, 1, 1, 0, bits, n);
        nv0 = nvalid;
        for (int k = 0; k < n; k++) sync_bit(bits[k], pol);
        for (int i = 0; i < 3; i++) sync_bit(1'b1, pol);
        chk("R9 sync valid count", nvalid - nv0, 1);
        chk("R9 sync word", cap_word, pol ? 9'h1A5 : 9'h0CE);
        chk("R9 sync flags", {cap_pe, cap_fe}, 0);
        sync_mode = 1'b0;
        par_mode = 2'd0;
        data_len = 3'd3;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_pulse_hold();
        logic [8:0] w;
        w = rx_word;
        repeat (100) @(negedge clk);
        chk("R10 single-cycle valid", dbl, 0);
        chk("R10 word held", rx_word, w);
        chk("R10 valid idle", rx_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            report();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_lengths();
        t_parity();
        t_framing();
        t_two_stop();
        t_glitch();
        t_majority();
        t_sync(1'b0);
        t_sync(1'b1);
        t_pulse_hold();
        done = 1'b1;
        report();
        $finish;
    end
endmodule